// File: doc/BRIEF.md
# TDM Daisy-Chain Slot Router

This block sits behind the serial audio input of a converter that shares one time-division-multiplexed stream with a second, downstream converter. It runs on the serial bit clock and finds frame boundaries from the frame clock. It cuts each 32-bit slot out of one or two serial data lines and keeps the eight channel words that belong to the local device. At the end of every frame it presents those words in parallel with a single-cycle strobe.

The slots meant for the device further down the chain are held in a small store. They are sent out again on one or two forwarding lines during the next frame, in the leading slot positions, so the downstream device sees an ordinary frame with its own data first. The layout input chooses between two arrangements. One-line uses sixteen slots on line 0. Two-line uses eight slots on each of two lines, so the bit clock can run at half the rate for the same number of channels.

Top module: `tdm_chain_router`

## Requirements
- R1: A frame begins at the rising clock edge where `fsync` is sampled high after being sampled low; the `sdin` bits sampled at that edge are frame bit 0. Slot n covers frame bits 32n to 32n+31 and carries its word most significant bit first.
- R2: With `dual_mode` = 0, a frame is 16 slots on `sdin[0]`. Slots 8 to 15 become channels 0 to 7 (L1, R1, L2, R2, L3, R3, L4, R4), and channel i is placed in `ch_data[32*i+31:32*i]`.
- R3: With `dual_mode` = 1, each line carries 8 slots per frame. Slots 4 to 7 of `sdin[0]` become channels 0 to 3, and slots 4 to 7 of `sdin[1]` become channels 4 to 7.
- R4: One clock after the edge that samples the last bit of a frame, `ch_valid` is high for exactly one cycle with that frame's eight words on `ch_data`. `ch_data` changes only when `ch_valid` is high.
- R5: With `dual_mode` = 0, slots 0 to 7 of a frame are replayed on `fwd_out[0]` in slots 0 to 7 of the next frame. The forwarded bit for frame position p is launched at the edge that samples position p-1, so it is stable across the edge that samples position p.
- R6: With `dual_mode` = 1, slots 0 to 3 of each line l are replayed on `fwd_out[l]` in slots 0 to 3 of the next frame, with the same bit alignment as R5.
- R7: Every position that is not a forwarded slot is driven as 0 on the forwarding lines. With `dual_mode` = 0, `fwd_out[1]` stays 0 and `sdin[1]` has no effect on any output.
- R8: Before the first frame start, and for the whole first frame after it, `fwd_out` is 0. `ch_valid` does not rise before the first frame has ended.
- R9: While `rst` is sampled high, `ch_valid`, `fwd_out` and `ch_data` are cleared at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock; data and frame clock are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dual_mode | input | 1 | Layout select: 0 = one line with 16 slots, 1 = two lines with 8 slots each; held static between resets |
| fsync | input | 1 | Frame clock; its rising edge marks frame bit 0 |
| sdin | input | 2 | Serial data lines 0 and 1 |
| fwd_out | output | 2 | Forwarding lines carrying the downstream device's slots |
| ch_valid | output | 1 | One-cycle strobe when a frame's local words are ready |
| ch_data | output | 256 | Eight 32-bit local channel words, channel i in bits 32i+31..32i |

## Verification
Each layout is driven with three word patterns. Tagged words encode line and slot in their bytes, so they expose any misrouted or shifted slot. Alternating all-ones and 0x80000001 words probe the first and last bit of every slot, which catches an off-by-one bit count or reversed bit order. Random words catch stuck or crossed data paths. In one-line frames, line 1 carries random data so that any leak from it shows up on the channels or on the second forwarding line. Comparing the first frame against later frames separates the empty-store case from real replay.

// File: rtl/tdm_chain_pkg.sv
package tdm_chain_pkg;
  typedef enum logic {
    LAYOUT_ONE_LINE = 1'b0,
    LAYOUT_TWO_LINE = 1'b1
  } tdm_layout_e;
  localparam int LINE_COUNT = 2;
endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
  parameter int SLOT_BITS = 32,
  parameter int LOCAL_CH  = 8,
  localparam int FRAME_ONE = SLOT_BITS * 2 * LOCAL_CH,
  localparam int FRAME_TWO = SLOT_BITS * LOCAL_CH,
  localparam int CW        = $clog2(FRAME_ONE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          two_line,
  input  logic          fsync,
  output logic [CW-1:0] pos,
  output logic [CW-1:0] nxt_pos,
  output logic          active,
  output logic          frame_end
);
  logic          fs_q;
  logic          synced_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;
  logic          sof;

  always_comb begin
    last      = two_line ? CW'(FRAME_TWO - 1) : CW'(FRAME_ONE - 1);
    sof       = fsync & ~fs_q;
    active    = sof | synced_q;
    if (sof)               pos = '0;
    else if (cnt_q == last) pos = '0;
    else                   pos = cnt_q + CW'(1);
    nxt_pos   = (pos == last) ? '0 : pos + CW'(1);
    frame_end = active && (pos == last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_q     <= 1'b0;
      synced_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      fs_q  <= fsync;
      cnt_q <= pos;
      if (sof) synced_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tdm_line_shifter.sv
module tdm_line_shifter #(
  parameter int SLOT_BITS = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sdin,
  output logic [SLOT_BITS-1:0] word
);
  logic [SLOT_BITS-2:0] sh_q;

  assign word = {sh_q, sdin};

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= word[SLOT_BITS-2:0];
  end
endmodule

// File: rtl/tdm_fwd_store.sv
module tdm_fwd_store #(
  parameter int SLOT_BITS = 32,
  parameter int DEPTH     = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int BW = $clog2(SLOT_BITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic [SLOT_BITS-1:0] wdata,
  input  logic                 rd_en,
  input  logic [AW-1:0]        raddr,
  input  logic [BW-1:0]        rbit,
  output logic                 dout
);
  logic [SLOT_BITS-1:0] mem [DEPTH];
  logic [SLOT_BITS-1:0] rword;

  assign rword = mem[raddr];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)        dout <= 1'b0;
    else if (rd_en) dout <= rword[rbit];
    else            dout <= 1'b0;
  end
endmodule

// File: rtl/tdm_chain_router.sv
module tdm_chain_router #(
  parameter int SLOT_BITS = 32,
  parameter int LOCAL_CH  = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          dual_mode,
  input  logic                          fsync,
  input  logic [1:0]                    sdin,
  output logic [1:0]                    fwd_out,
  output logic                          ch_valid,
  output logic [SLOT_BITS*LOCAL_CH-1:0] ch_data
);
  import tdm_chain_pkg::*;

  localparam int HALF      = LOCAL_CH / 2;
  localparam int FRAME_ONE = SLOT_BITS * 2 * LOCAL_CH;
  localparam int CW        = $clog2(FRAME_ONE);
  localparam int BW        = $clog2(SLOT_BITS);
  localparam int SW        = CW - BW;
  localparam int AW        = $clog2(LOCAL_CH);

  tdm_layout_e layout;
  assign layout = tdm_layout_e'(dual_mode);

  logic [CW-1:0] pos, nxt_pos;
  logic          active, frame_end;

  tdm_frame_timer #(.SLOT_BITS(SLOT_BITS), .LOCAL_CH(LOCAL_CH)) timer_i (
    .clk(clk), .rst(rst), .two_line(dual_mode), .fsync(fsync),
    .pos(pos), .nxt_pos(nxt_pos), .active(active), .frame_end(frame_end)
  );

  logic [SLOT_BITS-1:0] word [LINE_COUNT];

  logic [SW-1:0] slot, nslot, far_cnt;
  logic [BW-1:0] bitn, nbit, rbit;
  logic          word_end, primed_q, primed_now, done_q;
  logic [AW-1:0] ch_a, ch_b;

  always_comb begin
    slot       = pos[CW-1:BW];
    bitn       = pos[BW-1:0];
    nslot      = nxt_pos[CW-1:BW];
    nbit       = nxt_pos[BW-1:0];
    rbit       = BW'(SLOT_BITS - 1) - nbit;
    far_cnt    = (layout == LAYOUT_TWO_LINE) ? SW'(HALF) : SW'(LOCAL_CH);
    word_end   = active && (&bitn);
    primed_now = primed_q | frame_end;
    ch_a       = AW'(slot - far_cnt);
    ch_b       = ch_a + AW'(HALF);
  end

  for (genvar l = 0; l < LINE_COUNT; l++) begin : g_line
    logic line_on;
    assign line_on = (l == 0) || (layout == LAYOUT_TWO_LINE);

    tdm_line_shifter #(.SLOT_BITS(SLOT_BITS)) shift_i (
      .clk(clk), .rst(rst), .sdin(sdin[l]), .word(word[l])
    );

    tdm_fwd_store #(.SLOT_BITS(SLOT_BITS), .DEPTH(LOCAL_CH)) store_i (
      .clk(clk), .rst(rst),
      .we(word_end && line_on && (slot < far_cnt)),
      .waddr(slot[AW-1:0]), .wdata(word[l]),
      .rd_en(primed_now && line_on && (nslot < far_cnt)),
      .raddr(nslot[AW-1:0]), .rbit(rbit),
      .dout(fwd_out[l])
    );
  end

  logic [SLOT_BITS-1:0] stage [LOCAL_CH];

  always_ff @(posedge clk) begin
    if (word_end && (slot >= far_cnt)) begin
      stage[ch_a] <= word[0];
      if (layout == LAYOUT_TWO_LINE) stage[ch_b] <= word[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      primed_q <= 1'b0;
      done_q   <= 1'b0;
      ch_valid <= 1'b0;
      ch_data  <= '0;
    end else begin
      if (frame_end) primed_q <= 1'b1;
      done_q   <= frame_end;
      ch_valid <= done_q;
      if (done_q) begin
        for (int i = 0; i < LOCAL_CH; i++)
          ch_data[i*SLOT_BITS +: SLOT_BITS] <= stage[i];
      end
    end
  end
endmodule

// File: rtl/tdm_chain_router_chk.sv
module tdm_chain_router_chk #(
  parameter int SLOT_BITS = 32,
  parameter int LOCAL_CH  = 8
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          dual_mode,
  input logic                          fsync,
  input logic [1:0]                    fwd_out,
  input logic                          ch_valid,
  input logic [SLOT_BITS*LOCAL_CH-1:0] ch_data
);
  logic fs_q, seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_q   <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      fs_q <= fsync;
      if (fsync && !fs_q) seen_q <= 1'b1;
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ch_valid |=> !ch_valid); // R4
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !$stable(ch_data) |-> ch_valid); // R4
  AST_LINE1_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!dual_mode && $past(!dual_mode)) |-> (fwd_out[1] == 1'b0)); // R7
  AST_SILENT_BEFORE_SYNC: assert property (@(posedge clk) disable iff (rst)
    !seen_q |-> (fwd_out == 2'b00 && !ch_valid)); // R8
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!ch_valid && fwd_out == 2'b00 && ch_data == '0)); // R9
endmodule

bind tdm_chain_router tdm_chain_router_chk #(
  .SLOT_BITS(SLOT_BITS), .LOCAL_CH(LOCAL_CH)
) chk_i (
  .clk(clk), .rst(rst), .dual_mode(dual_mode), .fsync(fsync),
  .fwd_out(fwd_out), .ch_valid(ch_valid), .ch_data(ch_data)
);

// File: tb/tdm_chain_router_tb_top.sv
module tdm_chain_router_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SB = 32;
  localparam int NCH = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           dual_mode = 1'b0;
  logic           fsync = 1'b0;
  logic [1:0]     sdin = 2'b00;
  logic [1:0]     fwd_out;
  logic           ch_valid;
  logic [SB*NCH-1:0] ch_data;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int valid_due = -1;
  logic last_valid = 1'b0;

  logic [SB*NCH-1:0] exp_q [$];
  logic [SB-1:0] w [2][16];
  logic [SB-1:0] prev_w [2][16];
  bit have_prev = 0;

  tdm_chain_router #(.SLOT_BITS(SB), .LOCAL_CH(NCH)) dut_i (
    .clk(clk), .rst(rst), .dual_mode(dual_mode), .fsync(fsync),
    .sdin(sdin), .fwd_out(fwd_out), .ch_valid(ch_valid), .ch_data(ch_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req,
                       input logic [SB-1:0] act, input logic [SB-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the expected channel set whenever the strobe appears
  always @(negedge clk) begin
    if (!rst) begin
      if (ch_valid) begin
        check(!last_valid, "R4 strobe width", 32'(last_valid), 32'd0);
        check(cyc == valid_due, "R4 strobe timing", 32'(cyc), 32'(valid_due));
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected strobe", 32'd1, 32'd0);
        end else begin
          logic [SB*NCH-1:0] e;
          e = exp_q.pop_front();
          for (int i = 0; i < NCH; i++)
            check(ch_data[i*SB +: SB] == e[i*SB +: SB], "R2/R3 channel word",
                  ch_data[i*SB +: SB], e[i*SB +: SB]);
        end
      end
      last_valid <= ch_valid;
    end else begin
      last_valid <= 1'b0;
    end
  end

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      fsync = 1'b0;
      sdin  = 2'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic do_reset(input bit two);
    rst = 1'b1;
    dual_mode = two;
    fsync = 1'b0;
    have_prev = 0;
    repeat (3) @(negedge clk);
    check(ch_valid == 1'b0, "R9 reset strobe", 32'(ch_valid), 32'd0);
    check(fwd_out == 2'b00, "R9 reset forward", 32'(fwd_out), 32'd0);
    check(ch_data == '0, "R9 reset data", ch_data[SB-1:0], 32'd0);
    rst = 1'b0;
  endtask

  task automatic run_frame(input bit two, input int pat);
    int nslots, far, flen;
    logic [SB*NCH-1:0] e;
    nslots = two ? 8 : 16;
    far    = two ? 4 : 8;
    flen   = nslots * SB;
    for (int l = 0; l < 2; l++)
      for (int s = 0; s < 16; s++) begin
        case (pat)
          1:       w[l][s] = {8'hA5, 8'(l), 8'(s), 8'h5A};
          2:       w[l][s] = (s % 2 == 1) ? 32'hFFFF_FFFF : (32'h8000_0001 ^ 32'(l << 4));
          default: w[l][s] = $urandom;
        endcase
      end
    e = '0;
    if (!two) begin
      for (int c = 0; c < 8; c++) e[c*SB +: SB] = w[0][8 + c];          // R2
    end else begin
      for (int c = 0; c < 4; c++) begin
        e[c*SB +: SB]       = w[0][4 + c];                              // R3
        e[(c + 4)*SB +: SB] = w[1][4 + c];
      end
    end
    exp_q.push_back(e);
    for (int p = 0; p < flen; p++) begin
      int s, b;
      s = p / SB;
      b = p % SB;
      for (int l = 0; l < 2; l++) begin
        logic eb;
        eb = 1'b0;
        if (have_prev && s < far && (l == 0 || two)) eb = prev_w[l][s][SB-1-b];
        if (!have_prev)
          check(fwd_out[l] == eb, "R8 first frame forward", 32'(fwd_out[l]), 32'(eb));
        else if (s >= far || (l == 1 && !two))
          check(fwd_out[l] == eb, "R7 zero fill", 32'(fwd_out[l]), 32'(eb));
        else if (two)
          check(fwd_out[l] == eb, "R6 two-line replay", 32'(fwd_out[l]), 32'(eb));
        else
          check(fwd_out[l] == eb, "R5 one-line replay", 32'(fwd_out[l]), 32'(eb));
      end
      fsync   = (p < flen / 2);                                         // R1
      sdin[0] = w[0][s][SB-1-b];
      sdin[1] = two ? w[1][s][SB-1-b] : 1'($urandom);
      @(negedge clk);
    end
    valid_due = cyc + 1;
    prev_w = w;
    have_prev = 1;
  endtask

  initial begin
    do_reset(1'b0);
    idle(5);
    for (int k = 0; k < 5; k++)
      check(fwd_out == 2'b00 && !ch_valid, "R8 quiet before sync", 32'(fwd_out), 32'd0);
    run_frame(1'b0, 1);
    run_frame(1'b0, 0);
    run_frame(1'b0, 2);
    run_frame(1'b0, 0);
    idle(6);
    check(exp_q.size() == 0, "R4 one-line frames all strobed", 32'(exp_q.size()), 32'd0);
    do_reset(1'b1);
    idle(3);
    run_frame(1'b1, 1);
    run_frame(1'b1, 0);
    run_frame(1'b1, 2);
    idle(6);
    check(exp_q.size() == 0, "R4 two-line frames all strobed", 32'(exp_q.size()), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule